// File: doc/BRIEF.md
# Amplitude Zero-Suppression Encoder

This block shrinks one channel's sample record by removing stretches where the signal stays on the quiet side of an amplitude threshold. A record arrives as a stream of samples framed by start and end markers. Each sample is compared against a programmable threshold. The comparison can be set for positive pulses, where a sample must be above the threshold, or for negative pulses, where it must be below. A stretch of such samples is qualified only if it lasts at least a programmed minimum number of consecutive samples. Each qualified stretch is then widened by a programmable number of samples before it and after it, and the widened intervals are merged wherever they overlap or touch.

After the end marker, the block emits the compressed record on consecutive cycles. The first word is a size word. The record then continues as a sequence of runs. Each run starts with a control word giving its kind and its length. A kept run is followed by its samples, one per word. A skipped run carries no samples. The record is held internally so that the size word can go out first. One instance serves one channel.

Records up to `DEPTH` samples are supported. Samples beyond that count are discarded. A new record is accepted only once the previous one has been fully emitted.

Top module: `zs_encoder`

## Requirements
- R1: A sample counts as beyond the threshold when `neg_pol`=0 and `in_data` > `thr`, or when `neg_pol`=1 and `in_data` < `thr`. A sample equal to `thr` never counts.
- R2: A stretch of consecutive beyond-threshold samples qualifies when its length is at least `min_len`. A `min_len` of 0 acts as 1. A stretch that runs into the last sample of the record is judged the same way.
- R3: A qualified stretch from sample s to sample e keeps samples max(0, s−`lbk`) through min(n−1, e+`lfw`), where n is the record length.
- R4: Kept intervals that overlap or are adjacent form a single kept run. Intervals separated by at least one sample give a kept run, a skip run and a kept run in that order.
- R5: A control word has bit 31 = 1 for a kept run and 0 for a skipped run, and bits 30:0 hold the run length, which is never zero. The runs cover the record in sample order and alternate in kind.
- R6: The first output word of a record is the size word. Its value is the total number of words emitted for the record, including the size word itself.
- R7: A record with no qualified stretch produces exactly two words: size 2, then a skip control word whose length is n.
- R8: Each kept sample is emitted as one word holding the sample zero-extended in bits `DW`−1:0, in its original order, directly after its run's control word.
- R9: The size word appears one cycle after the cycle in which the end-marked sample is taken. The remaining words follow on consecutive cycles. `out_last` is high only with the final word, and `out_valid` is low on the cycle after it.
- R10: Samples offered before a start marker, and samples offered while a record is being emitted, are ignored and produce no output.
- R11: During and after reset, with no input, `out_valid` and `out_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present on `in_data` |
| in_sop | input | 1 | Sample is the first of a record |
| in_eop | input | 1 | Sample is the last of a record |
| in_data | input | DW | Sample value, unsigned |
| thr | input | DW | Amplitude threshold |
| neg_pol | input | 1 | 1 selects under-threshold (negative pulse) comparison |
| min_len | input | LW | Minimum qualifying stretch length |
| lbk | input | LW | Samples kept before a qualified stretch |
| lfw | input | LW | Samples kept after a qualified stretch |
| out_valid | output | 1 | Output word present |
| out_last | output | 1 | Output word is the final word of the record |
| out_data | output | OW | Size, control or sample word |

## Verification
The end-marked sample is captured at one clock edge. Output words are registered, so nothing is visible until the next edge, which brings the size word. Each further edge brings one more word, until the one flagged last. The bench samples on falling edges. It checks that `out_valid` is still low in the half-cycle straight after the end-marked sample has been taken, then compares one word per falling edge against a stream it builds itself from the requirements. It confirms silence on the falling edge after the final word. The ignore checks drive inputs while the stream is running and then watch the outputs for several idle cycles.

// File: rtl/zs_encoder.sv
module zs_encoder #(
  parameter int DW    = 14,
  parameter int DEPTH = 64,
  parameter int LW    = 8,
  parameter int OW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] thr,
  input  logic          neg_pol,
  input  logic [LW-1:0] min_len,
  input  logic [LW-1:0] lbk,
  input  logic [LW-1:0] lfw,
  output logic          out_valid,
  output logic          out_last,
  output logic [OW-1:0] out_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(DEPTH + 1);
  localparam int XW = ((IW > LW) ? IW : LW) + 2;
  localparam logic [IW-1:0] DEPTH_I = IW'(DEPTH);

  typedef enum logic [1:0] {S_RX, S_SIZE, S_CTRL, S_DATA} st_t;

  st_t              st;
  logic             open;
  logic [IW-1:0]    n, run_len, run_start, p;
  logic [DEPTH-1:0] keep;
  logic [DW-1:0]    mem [DEPTH];

  // capture side
  logic          take, stor, over, close_mid, close_eop, closing;
  logic [IW-1:0] idx, rl;
  logic [LW-1:0] mlen;
  logic [XW-1:0] cl_start, cl_end, lo, hi;
  logic [DEPTH-1:0] rmask;

  assign take  = (st == S_RX) && in_valid && (in_sop || open);
  assign idx   = in_sop ? '0 : n;
  assign stor  = take && (idx < DEPTH_I);
  assign over  = neg_pol ? (in_data < thr) : (in_data > thr);
  assign rl    = in_sop ? '0 : run_len;
  assign mlen  = (min_len == '0) ? LW'(1) : min_len;

  assign close_mid = stor && !over && (rl != '0) && (XW'(rl) >= XW'(mlen));
  assign close_eop = stor && over && in_eop && (XW'(rl) + XW'(1) >= XW'(mlen));
  assign closing   = close_mid || close_eop;

  assign cl_start = (close_eop && rl == '0) ? XW'(idx) : XW'(run_start);
  assign cl_end   = close_eop ? XW'(idx) : XW'(idx) - XW'(1);
  assign lo       = (cl_start >= XW'(lbk)) ? cl_start - XW'(lbk) : '0;
  assign hi       = cl_end + XW'(lfw);

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rmask[i] = closing && (XW'(i) >= lo) && (XW'(i) <= hi);
  end

  // size of the compressed record
  logic [XW-1:0] kept, runs;
  logic          prv;
  logic [OW-1:0] size_w;

  always_comb begin
    kept = '0;
    runs = '0;
    prv  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (XW'(i) < XW'(n)) begin
        kept = kept + XW'(keep[i]);
        if (i == 0 || keep[i] != prv) runs = runs + XW'(1);
        prv = keep[i];
      end
    end
  end
  assign size_w = OW'(kept) + OW'(runs) + OW'(1);

  // run scanner from position p
  logic          cur, nxt, go;
  logic [XW-1:0] rlen;

  always_comb begin
    cur = 1'b0;
    nxt = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (XW'(i) == XW'(p)) cur = keep[i];
      if (XW'(i) == XW'(p) + XW'(1)) nxt = keep[i];
    end
    rlen = '0;
    go   = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (XW'(i) >= XW'(p) && XW'(i) < XW'(n)) begin
        if (go && keep[i] == cur) rlen = rlen + XW'(1);
        else go = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stor) mem[idx[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RX;
      open      <= 1'b0;
      n         <= '0;
      run_len   <= '0;
      run_start <= '0;
      keep      <= '0;
      p         <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (st)
        S_RX: begin
          if (stor) begin
            n       <= idx + IW'(1);
            run_len <= over ? rl + IW'(1) : '0;
            if (over && rl == '0) run_start <= idx;
            keep    <= (in_sop ? '0 : keep) | rmask;
          end
          if (take) begin
            open <= !in_eop;
            if (in_eop) st <= S_SIZE;
          end
        end
        S_SIZE: begin
          out_valid <= 1'b1;
          out_data  <= size_w;
          p         <= '0;
          st        <= S_CTRL;
        end
        S_CTRL: begin
          out_valid <= 1'b1;
          out_data  <= {cur, (OW-1)'(rlen)};
          if (cur) st <= S_DATA;
          else begin
            p <= p + IW'(rlen);
            if (XW'(p) + rlen == XW'(n)) begin
              out_last <= 1'b1;
              st       <= S_RX;
            end
          end
        end
        S_DATA: begin
          out_valid <= 1'b1;
          out_data  <= OW'(mem[p[AW-1:0]]);
          p         <= p + IW'(1);
          if (XW'(p) + XW'(1) == XW'(n)) begin
            out_last <= 1'b1;
            st       <= S_RX;
          end else if (!nxt) st <= S_CTRL;
        end
        default: st <= S_RX;
      endcase
    end
  end

  // R9
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R9
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  // R5
  ctrl_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CTRL) |-> (rlen != '0) && (XW'(p) + rlen <= XW'(n)));

  // R6
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SIZE) |=> (out_valid && st == S_CTRL));

  // R10
  rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RX) |-> !open);

endmodule

// File: tb/sim_zs_encoder.sv
`timescale 1ns/1ps
module sim_zs_encoder;
  localparam int DW = 14, DEPTH = 64, LW = 8, OW = 32;
  localparam int NV = 9;
  // R2 R3 R4 R5 R6 R7 R8 vectors: length, pattern, polarity, min, back, forward, expected size
  localparam int          V_N   [NV] = '{16, 16, 16, 20, 20, 12, 8, 10, 1};
  localparam logic [31:0] V_PAT [NV] = '{32'h00E0, 32'h00E0, 32'h00E0, 32'h0318, 32'h0318,
                                         32'h0C03, 32'h00FF, 32'h0010, 32'h0000};
  localparam int          V_NEG [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam int          V_MIN [NV] = '{3, 4, 3, 2, 2, 2, 8, 0, 1};
  localparam int          V_LBK [NV] = '{1, 1, 0, 2, 1, 3, 0, 0, 0};
  localparam int          V_LFW [NV] = '{1, 1, 0, 1, 1, 3, 0, 0, 0};
  localparam int          V_SIZE[NV] = '{9, 2, 7, 14, 14, 14, 10, 5, 2};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, neg_pol = 0;
  logic [DW-1:0] in_data = '0, thr = '0;
  logic [LW-1:0] min_len = '0, lbk = '0, lfw = '0;
  logic out_valid, out_last;
  logic [OW-1:0] out_data;

  always #2.5 clk = ~clk;

  zs_encoder #(.DW(DW), .DEPTH(DEPTH), .LW(LW), .OW(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .thr(thr), .neg_pol(neg_pol), .min_len(min_len), .lbk(lbk),
    .lfw(lfw), .out_valid(out_valid), .out_last(out_last), .out_data(out_data));

  int pass_n = 0, fail_n = 0;
  bit finished = 0;
  logic [DW-1:0] smp [0:DEPTH-1];
  logic [31:0] exp_w [0:2*DEPTH+1];
  int exp_cnt;
  logic [31:0] got_size;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic build_exp(int n, int t, int ng, int mn, int lb, int lf);
    bit ov [0:DEPTH];
    bit kp [0:DEPTH];
    int i, s, e, mneff, cnt;
    mneff = (mn == 0) ? 1 : mn;
    for (int k = 0; k <= DEPTH; k++) begin
      ov[k] = 0;
      kp[k] = 0;
    end
    for (int k = 0; k < n; k++) ov[k] = ng ? (int'(smp[k]) < t) : (int'(smp[k]) > t);
    i = 0;
    while (i < n) begin
      if (ov[i]) begin
        s = i;
        while (i < n && ov[i]) i++;
        e = i - 1;
        if (e - s + 1 >= mneff)
          for (int k = ((s - lb) < 0 ? 0 : s - lb); k <= ((e + lf) > n - 1 ? n - 1 : e + lf); k++)
            kp[k] = 1;
      end else i++;
    end
    cnt = 1;
    i = 0;
    while (i < n) begin
      s = i;
      while (i < n && kp[i] == kp[s]) i++;
      exp_w[cnt] = {kp[s], 31'(i - s)};
      cnt++;
      if (kp[s])
        for (int k = s; k < i; k++) begin
          exp_w[cnt] = 32'(smp[k]);
          cnt++;
        end
    end
    exp_w[0] = 32'(cnt);
    exp_cnt = cnt;
  endtask

  task automatic run_record(int n, int t, int ng, int mn, int lb, int lf, bit noise, string req);
    build_exp(n, t, ng, mn, lb, lf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      thr = DW'(t); neg_pol = ng[0]; min_len = LW'(mn); lbk = LW'(lb); lfw = LW'(lf);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == n - 1); in_data = smp[i];
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    chk(out_valid == 0, "R9", "no word in capture cycle", out_valid, 0);
    for (int w = 0; w < exp_cnt; w++) begin
      @(negedge clk);
      if (noise && w < exp_cnt - 1) begin
        in_valid = 1; in_sop = 1; in_eop = 1; in_data = 14'd3000;
      end else begin
        in_valid = 0; in_sop = 0; in_eop = 0;
      end
      if (w == 0) got_size = out_data;
      chk(out_valid && out_data == exp_w[w] && out_last == (w == exp_cnt - 1),
          req, $sformatf("word %0d (valid %0d last %0d)", w, out_valid, out_last),
          out_data, exp_w[w]);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    chk(out_valid == 0, "R9", "quiet after last word", out_valid, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fail_n++;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_last == 0, "R11", "outputs in reset", {out_valid, out_last}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_valid == 0 && out_last == 0, "R11", "outputs after reset", {out_valid, out_last}, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < V_N[v]; i++)
        smp[i] = V_PAT[v][i] ? (V_NEG[v] != 0 ? DW'(100 + i) : DW'(1000 + i))
                             : (V_NEG[v] != 0 ? DW'(1000 + i) : DW'(100 + i));
      run_record(V_N[v], 500, V_NEG[v], V_MIN[v], V_LBK[v], V_LFW[v], 0, "R1/R2/R3/R4/R5/R8");
      chk(got_size == 32'(V_SIZE[v]), "R6", $sformatf("size of vector %0d", v), got_size, V_SIZE[v]);
    end

    // R1 samples equal to the threshold never count, either polarity
    for (int i = 0; i < 6; i++) smp[i] = 14'd500;
    run_record(6, 500, 0, 1, 0, 0, 0, "R1");
    chk(got_size == 2, "R1", "equal samples positive", got_size, 2);
    run_record(6, 500, 1, 1, 0, 0, 0, "R1");
    chk(got_size == 2, "R7", "equal samples negative", got_size, 2);

    // R10 samples before a start marker are ignored
    repeat (3) begin
      @(negedge clk);
      in_valid = 1; in_sop = 0; in_eop = 0; in_data = 14'd2000;
    end
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0, "R10", "no output from unframed samples", out_valid, 0);
    for (int i = 0; i < 6; i++) smp[i] = DW'(50 + i);
    run_record(6, 500, 0, 1, 0, 0, 1, "R10");
    chk(got_size == 2, "R10", "unframed and in-flight samples ignored", got_size, 2);

    // R10 no record started by samples offered during emission
    begin
      int seen = 0;
      repeat (8) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      chk(seen == 0, "R10", "idle after noisy emission", seen, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule